// File: doc/BRIEF.md
# Protected Remap Register Lock Unit

This unit keeps a small bank of pin-remapping control registers safe from stray writes. Software reaches it through two write ports. The first is a byte-wide control port that carries a lock bit. The second writes the protected register bank. While the lock is set, bank writes complete on the bus without error, but the registers keep their contents.

To change the lock, software writes two fixed key bytes to the control port and then writes the new lock value. These three writes must come on consecutive clock cycles. Once the lock is open it stays open, so software can run any number of bank updates and then close the lock with a second key sequence. A one-way configuration input can be driven high. In that case a set lock cannot be cleared until the next reset. With the input low, software may run as many sessions as it needs.

Each protected register has a shadow copy held in hardware. The unit compares every live register with its shadow on every cycle. A difference that no authorized write caused raises a configuration-mismatch reset request. A test-only force port flips bits in a live register so this path can be checked.

Top module: `remap_lock_unit`

## Requirements
- R1: Synchronous reset clears the lock bit to 0, returns the key detector to idle, loads register i and its shadow with 0x20 + 3*i, and clears the mismatch request.
- R2: While the lock bit is 1, a bank write leaves every bank register unchanged.
- R3: A control write of 0x46, then a control write of 0x57 in the next cycle, then a control write in the cycle after that sets the lock bit to bit 6 of that third byte. The new lock value is visible after the clock edge of the third write. The other seven bits of the third byte are ignored.
- R4: The sequence aborts and the third write is ignored in two cases: a wrong second byte, or a cycle without a control write between the steps. Control writes outside a complete sequence never change the lock bit.
- R5: The lock bit holds its value without further writes. While it is 0, every bank write updates the addressed register after the edge that samples it.
- R6: While one_way_cfg is 1 and the lock bit is 1, a complete sequence with bit 6 cleared leaves the lock bit at 1. Only reset clears it.
- R7: While one_way_cfg is 0, the lock can be opened and closed repeatedly.
- R8: Authorized bank writes update the live register and its shadow together, so they never raise the mismatch request.
- R9: A live register that differs from its shadow raises mismatch_rst_o one clock after the difference appears. The request stays high until reset, even if a later bank write makes the two agree again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| one_way_cfg | input | 1 | 1: once set, the lock cannot be cleared before reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte data; bit 6 is the lock value |
| bank_we | input | 1 | Protected bank write strobe |
| bank_addr | input | AW | Bank register index |
| bank_wdata | input | REG_W | Bank write data |
| fault_we | input | 1 | Test-only: corrupt a live register |
| fault_addr | input | AW | Test-only: register to corrupt |
| fault_mask | input | REG_W | Test-only: bits to invert |
| lock_o | output | 1 | Current lock bit |
| bank_q | output | NUM_REGS*REG_W | Live register contents; register i at bits [i*REG_W +: REG_W] |
| mismatch_rst_o | output | 1 | Sticky configuration-mismatch reset request |

## Verification
If the key detector sits in the wrong state, the symptom shows up at lock_o right after the edge of the third control write. The lock either moves when it should not, or fails to move when it should. An error in the write gate or in the one-way rule shows on bank_q one cycle after the bank write it wrongly accepted or dropped. A register that does not match its shadow, or a faulty comparator, shows on mismatch_rst_o exactly one cycle after the corrupting edge. The bench follows all of these with a cycle-level model and checks them on every clock.

// File: rtl/remap_lock_pkg.sv
package remap_lock_pkg;

    localparam int CTL_W = 8;
    localparam logic [CTL_W-1:0] KEY_FIRST  = 8'h46;
    localparam logic [CTL_W-1:0] KEY_SECOND = 8'h57;
    localparam int LOCK_POS = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HALF = 2'd1,
        SEQ_OPEN = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic             we;
        logic [CTL_W-1:0] data;
    } ctl_wr_t;

    // Reset value of bank register idx
    function automatic int reg_default(input int base, input int idx);
        return base + 3 * idx;
    endfunction

    // Lock value after an authorized lock write
    function automatic logic lock_next(input logic cur, input logic req, input logic one_way);
        return (one_way && cur) ? 1'b1 : req;
    endfunction

endpackage

// File: rtl/remap_key_seq.sv
module remap_key_seq
    import remap_lock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctl_wr_t ctl,
    input  logic    one_way,
    output logic    lock_q
);
    seq_state_t state_q, state_d;
    logic       lock_d;
    logic       lock_wr;

    always_comb begin
        state_d = SEQ_IDLE;
        lock_wr = 1'b0;
        unique case (state_q)
            SEQ_IDLE: state_d = (ctl.we && ctl.data == KEY_FIRST)  ? SEQ_HALF : SEQ_IDLE;
            SEQ_HALF: state_d = (ctl.we && ctl.data == KEY_SECOND) ? SEQ_OPEN : SEQ_IDLE;
            SEQ_OPEN: begin
                lock_wr = ctl.we;
                state_d = SEQ_IDLE;
            end
            default:  state_d = SEQ_IDLE;
        endcase
        lock_d = lock_wr ? lock_next(lock_q, ctl.data[LOCK_POS], one_way) : lock_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end
endmodule

// File: rtl/remap_reg_bank.sv
module remap_reg_bank
    import remap_lock_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int DEF_BASE = 32,
    localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int QW      = NUM_REGS * REG_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             flt_en,
    input  logic [AW-1:0]    flt_addr,
    input  logic [REG_W-1:0] flt_mask,
    output logic [QW-1:0]    live_flat,
    output logic [QW-1:0]    shadow_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] DEF_VAL = REG_W'(reg_default(DEF_BASE, i));
        logic [REG_W-1:0] live_q, shad_q;
        logic             hit_wr, hit_flt;
        logic [REG_W-1:0] flip;

        always_comb begin
            hit_wr  = wr_en  && (wr_addr  == AW'(i));
            hit_flt = flt_en && (flt_addr == AW'(i));
            flip    = hit_flt ? flt_mask : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= DEF_VAL;
                shad_q <= DEF_VAL;
            end else if (hit_wr) begin
                live_q <= wr_data ^ flip;
                shad_q <= wr_data;
            end else begin
                live_q <= live_q ^ flip;
            end
        end

        assign live_flat[i*REG_W +: REG_W]   = live_q;
        assign shadow_flat[i*REG_W +: REG_W] = shad_q;
    end
endmodule

// File: rtl/remap_shadow_cmp.sv
module remap_shadow_cmp #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    localparam int QW      = NUM_REGS * REG_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] live_flat,
    input  logic [QW-1:0] shadow_flat,
    output logic          req_q
);
    logic [NUM_REGS-1:0] diff;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
        assign diff[i] = live_flat[i*REG_W +: REG_W] != shadow_flat[i*REG_W +: REG_W];
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_q | (|diff);
    end
endmodule

// File: rtl/remap_lock_unit.sv
module remap_lock_unit
    import remap_lock_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int DEF_BASE = 32,
    localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int QW      = NUM_REGS * REG_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             one_way_cfg,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             bank_we,
    input  logic [AW-1:0]    bank_addr,
    input  logic [REG_W-1:0] bank_wdata,
    input  logic             fault_we,
    input  logic [AW-1:0]    fault_addr,
    input  logic [REG_W-1:0] fault_mask,
    output logic             lock_o,
    output logic [QW-1:0]    bank_q,
    output logic             mismatch_rst_o
);
    ctl_wr_t       ctl;
    logic          lock_q;
    logic          wr_ok;
    logic [QW-1:0] live_flat, shadow_flat;

    assign ctl.we   = ctl_we;
    assign ctl.data = ctl_wdata;
    assign wr_ok    = bank_we && !lock_q;

    remap_key_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .one_way (one_way_cfg),
        .lock_q  (lock_q)
    );

    remap_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .DEF_BASE (DEF_BASE)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_ok),
        .wr_addr     (bank_addr),
        .wr_data     (bank_wdata),
        .flt_en      (fault_we),
        .flt_addr    (fault_addr),
        .flt_mask    (fault_mask),
        .live_flat   (live_flat),
        .shadow_flat (shadow_flat)
    );

    remap_shadow_cmp #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .live_flat   (live_flat),
        .shadow_flat (shadow_flat),
        .req_q       (mismatch_rst_o)
    );

    assign lock_o = lock_q;
    assign bank_q = live_flat;
endmodule

// File: rtl/remap_lock_unit_chk.sv
module remap_lock_unit_chk #(
    parameter int QW = 32
)(
    input logic          clk,
    input logic          rst,
    input logic          one_way_cfg,
    input logic          ctl_we,
    input logic          bank_we,
    input logic          fault_we,
    input logic          lock_o,
    input logic [QW-1:0] bank_q,
    input logic          mismatch_rst_o
);
    // R3 / R4: the lock moves only on an edge that sampled a control write
    p_lock_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_o) |-> $past(ctl_we));

    // R6: a set lock under the one-way option stays set
    p_one_way_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (one_way_cfg && lock_o) |=> lock_o);

    // R2: locked bank writes leave the bank untouched
    p_locked_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (lock_o && bank_we && !fault_we) |=> $stable(bank_q));

    // R9: the request is sticky
    p_req_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        mismatch_rst_o |=> mismatch_rst_o);

    // R8: the request only rises two edges after a corruption
    p_no_false_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mismatch_rst_o) |-> $past(fault_we, 2));
endmodule

bind remap_lock_unit remap_lock_unit_chk #(.QW(QW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .one_way_cfg    (one_way_cfg),
    .ctl_we         (ctl_we),
    .bank_we        (bank_we),
    .fault_we       (fault_we),
    .lock_o         (lock_o),
    .bank_q         (bank_q),
    .mismatch_rst_o (mismatch_rst_o)
);

// File: tb/remap_lock_unit_bench.sv
module remap_lock_unit_bench;
    localparam int CLK_P = 10;
    localparam int NR    = 4;
    localparam int RW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          one_way_cfg = 1'b0;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          bank_we = 1'b0;
    logic [1:0]    bank_addr = '0;
    logic [RW-1:0] bank_wdata = '0;
    logic          fault_we = 1'b0;
    logic [1:0]    fault_addr = '0;
    logic [RW-1:0] fault_mask = '0;
    logic          lock_o;
    logic [NR*RW-1:0] bank_q;
    logic          mismatch_rst_o;

    int total = 0;
    int bad   = 0;

    // behavioural model
    int            m_step;   // 0 idle, 1 first key seen, 2 window open
    bit            m_lock;
    bit            m_req;
    logic [RW-1:0] m_live[NR];
    logic [RW-1:0] m_shad[NR];

    always #(CLK_P/2) clk = ~clk;

    remap_lock_unit u_remap_lock_unit (
        .clk(clk), .rst(rst), .one_way_cfg(one_way_cfg),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
        .fault_we(fault_we), .fault_addr(fault_addr), .fault_mask(fault_mask),
        .lock_o(lock_o), .bank_q(bank_q), .mismatch_rst_o(mismatch_rst_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "lock", int'(lock_o), int'(m_lock));
        chk(req, "mismatch", int'(mismatch_rst_o), int'(m_req));
        for (int i = 0; i < NR; i++)
            chk(req, $sformatf("reg%0d", i), int'(bank_q[i*RW +: RW]), int'(m_live[i]));
    endtask

    task automatic model_reset();
        m_step = 0; m_lock = 0; m_req = 0;
        for (int i = 0; i < NR; i++) begin
            m_live[i] = RW'(32 + 3*i);
            m_shad[i] = RW'(32 + 3*i);
        end
    endtask

    task automatic model_edge();
        bit diff = 0;
        for (int i = 0; i < NR; i++) if (m_live[i] != m_shad[i]) diff = 1;
        if (rst) begin
            model_reset();
            return;
        end
        case (m_step)
            0: m_step = (ctl_we && ctl_wdata == 8'h46) ? 1 : 0;
            1: m_step = (ctl_we && ctl_wdata == 8'h57) ? 2 : 0;
            default: begin
                if (ctl_we && !(one_way_cfg && m_lock)) m_lock = ctl_wdata[6];
                m_step = 0;
            end
        endcase
        if (bank_we && !lock_o) begin
            m_live[bank_addr] = bank_wdata;
            m_shad[bank_addr] = bank_wdata;
        end
        if (fault_we) m_live[fault_addr] = m_live[fault_addr] ^ fault_mask;
        if (diff) m_req = 1;
    endtask

    // one clock: inputs already set at negedge, model follows the edge, compare at next negedge
    task automatic cyc(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(req);
        ctl_we = 0; bank_we = 0; fault_we = 0;
    endtask

    task automatic ctl_w(input logic [7:0] d, input string req);
        ctl_we = 1; ctl_wdata = d; cyc(req);
    endtask

    task automatic bank_w(input int a, input logic [RW-1:0] d, input string req);
        bank_we = 1; bank_addr = 2'(a); bank_wdata = d; cyc(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) cyc(req);
    endtask

    task automatic do_reset();
        rst = 1; idle(2, "R1"); rst = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        compare_all("R1");

        // R5: reset leaves lock open, writes land and persist
        bank_w(0, 8'hA1, "R5");
        bank_w(3, 8'h5C, "R5");
        idle(3, "R5");

        // R3: lock with full sequence; non-lock bits ignored
        ctl_w(8'h46, "R3"); ctl_w(8'h57, "R3"); ctl_w(8'hFF & 8'h7F, "R3");
        chk("R3", "locked", int'(lock_o), 1);

        // R2: locked writes ignored
        bank_w(1, 8'h99, "R2");
        bank_w(0, 8'h00, "R2");

        // R4: wrong second key, then gap between keys
        ctl_w(8'h46, "R4"); ctl_w(8'h58, "R4"); ctl_w(8'h00, "R4");
        ctl_w(8'h46, "R4"); idle(1, "R4"); ctl_w(8'h57, "R4"); ctl_w(8'h00, "R4");
        ctl_w(8'h46, "R4"); ctl_w(8'h57, "R4"); idle(1, "R4"); ctl_w(8'h00, "R4");
        ctl_w(8'h00, "R4");
        chk("R4", "still locked", int'(lock_o), 1);

        // R3/R5: unlock with bit 6 clear, several writes in one session
        ctl_w(8'h46, "R3"); ctl_w(8'h57, "R3"); ctl_w(8'hBF, "R3");
        chk("R3", "unlocked", int'(lock_o), 0);
        bank_w(1, 8'h11, "R5"); bank_w(2, 8'h22, "R5"); bank_w(1, 8'h33, "R8");
        idle(2, "R8");

        // R6: one-way option
        one_way_cfg = 1;
        ctl_w(8'h46, "R6"); ctl_w(8'h57, "R6"); ctl_w(8'h40, "R6");
        ctl_w(8'h46, "R6"); ctl_w(8'h57, "R6"); ctl_w(8'h00, "R6");
        chk("R6", "lock held", int'(lock_o), 1);
        bank_w(2, 8'hEE, "R6");
        do_reset();
        compare_all("R1");

        // R7: repeated sessions without the one-way option
        one_way_cfg = 0;
        for (int s = 0; s < 3; s++) begin
            ctl_w(8'h46, "R7"); ctl_w(8'h57, "R7"); ctl_w(8'h40, "R7");
            bank_w(s, 8'h77, "R7");
            ctl_w(8'h46, "R7"); ctl_w(8'h57, "R7"); ctl_w(8'h00, "R7");
            bank_w(s, 8'h60 + 8'(s), "R7");
        end
        chk("R7", "reopened", int'(lock_o), 0);

        // R9: corruption raises request one clock later, sticky
        fault_we = 1; fault_addr = 2; fault_mask = 8'h01; cyc("R9");
        chk("R9", "not yet", int'(mismatch_rst_o), 0);
        idle(1, "R9");
        chk("R9", "raised", int'(mismatch_rst_o), 1);
        bank_w(2, 8'h44, "R9");
        idle(3, "R9");
        chk("R9", "sticky", int'(mismatch_rst_o), 1);
        do_reset();
        compare_all("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule